// File: doc/BRIEF.md
# Monitor Threshold Flag Generator

This block holds alarm and warning limits for five live monitor channels and turns each new reading into high and low flags. The channels are, in fixed order, internal temperature, supply voltage, laser bias current, transmitted optical power and received optical power. A byte-wide register port lets a host write the limits and read back limits, stored readings and the packed flag bytes. Each channel has a 16-bit sample input and a one-cycle update strobe. Temperature is compared as a signed value; the other four channels are compared as unsigned values.

A strobe loads the reading into the register space and refreshes that channel's four flags in the same clock edge. The flags follow the latest comparison; they are not sticky. Limits changed without a fresh strobe affect the flags only at that channel's next strobe.

Top module: `dmon_alarm_flags`

## Requirements
- R1: After reset every limit byte, reading byte and flag byte reads as 0x00.
- R2: Limits occupy bytes 0 to 39. Channel c (0 temperature, 1 supply, 2 bias, 3 transmit power, 4 receive power) and limit kind k (0 high alarm, 1 low alarm, 2 high warning, 3 low warning) sit at byte 8c+2k, holding the upper byte, and at 8c+2k+1, holding the lower byte. A write there reads back from the next cycle on.
- R3: The reading of channel c is readable at byte 96+2c (upper byte) and 97+2c (lower byte), from the cycle after its strobe. Without a strobe it holds.
- R4: A high flag is 1 exactly when the reading is strictly greater than its high limit. Equality gives 0.
- R5: A low flag is 1 exactly when the reading is strictly less than its low limit. Equality gives 0.
- R6: Channel 0 compares as two's complement, so 0xFFFF is below a low limit of 0x0000. Channels 1 to 4 compare as unsigned, so 0xFFFF is above a high limit of 0x7FFF.
- R7: Alarm byte 112 holds, from bit 7 to bit 0, high then low flags of channels 0, 1, 2 and 3. Byte 113 bit 7 is the channel 4 high alarm and bit 6 the channel 4 low alarm. Bits 5 to 0 read 0.
- R8: Warning bytes 116 and 117 use the layout of bytes 112 and 113 and compare against the warning limits.
- R9: A channel's flags change only at the edge where its strobe is high. They are computed from the limits held before that edge, so a limit write in the same cycle applies only from the next strobe.
- R10: Writes to any byte outside 0 to 39 have no effect. Bytes outside the limit, reading and flag locations read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| smp_data | input | 80 | Readings; channel c on bits 16c+15 down to 16c |
| smp_upd | input | 5 | Per-channel update strobe, bit c for channel c |

## Verification
The two functions that can meet in one cycle are a limit byte write and a strobe on the same channel. The bench provokes this on purpose, both directed and inside the random mix. It writes a limit byte that flips the outcome of the comparison and strobes that channel at the same edge. The reference model computes the flags from the limits held before the edge and applies the write afterwards. The flag bytes read on the next cycle must match the old limit, and a later strobe of the same value must match the new one.

// File: rtl/dmon_pkg.sv
package dmon_pkg;
    // Register space landmarks (byte addresses)
    localparam int RT_BASE_ADDR  = 96;
    localparam int ALM_HI_ADDR   = 112;
    localparam int ALM_LO_ADDR   = 113;
    localparam int WRN_HI_ADDR   = 116;
    localparam int WRN_LO_ADDR   = 117;

    // Limit kinds inside one channel's 8-byte slot
    typedef enum logic [1:0] {
        LIM_HI_ALM = 2'd0,
        LIM_LO_ALM = 2'd1,
        LIM_HI_WRN = 2'd2,
        LIM_LO_WRN = 2'd3
    } lim_kind_e;

    localparam int LIM_KINDS     = 4;
    localparam int BYTES_PER_LIM = 2;
endpackage

// File: rtl/dmon_limit_bank.sv
module dmon_limit_bank
    import dmon_pkg::*;
#(
    parameter int NCH = 5,
    parameter int AW  = 8,
    localparam int LIM_BYTES = NCH * LIM_KINDS * BYTES_PER_LIM,
    localparam int LAW       = $clog2(LIM_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [7:0]                  wr_data,
    output logic [LIM_BYTES-1:0][7:0]   lim_o
);
    localparam logic [AW-1:0] LIM_TOP = AW'(LIM_BYTES);

    typedef struct packed {
        logic [LIM_BYTES-1:0][7:0] b;
    } bank_st_t;

    bank_st_t s_d, s_q;
    logic     hit;

    assign hit = wr_en && (wr_addr < LIM_TOP);

    always_comb begin
        s_d = s_q;
        if (hit) begin
            s_d.b[wr_addr[LAW-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lim_o = s_q.b;

    // R2
    lim_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < LIM_TOP) |=> lim_o[$past(wr_addr[LAW-1:0])] == $past(wr_data));

    // R10
    lim_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr < LIM_TOP) |=> $stable(lim_o));
endmodule

// File: rtl/dmon_sample_regs.sv
module dmon_sample_regs #(
    parameter int NCH = 5,
    parameter int SW  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           upd,
    input  logic [NCH-1:0][SW-1:0]   smp_in,
    output logic [NCH-1:0][SW-1:0]   smp_o
);
    typedef struct packed {
        logic [NCH-1:0][SW-1:0] v;
    } smp_st_t;

    smp_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NCH; c++) begin
            if (upd[c]) s_d.v[c] = smp_in[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp_o = s_q.v;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3
        smp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd[c] |=> smp_o[c] == $past(smp_in[c]));
        // R3
        smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !upd[c] |=> $stable(smp_o[c]));
    end
endmodule

// File: rtl/dmon_flag_cmp.sv
module dmon_flag_cmp
    import dmon_pkg::*;
#(
    parameter int             NCH         = 5,
    parameter int             SW          = 16,
    parameter logic [NCH-1:0] SIGNED_MASK = 5'b00001,
    localparam int LIM_BYTES = NCH * LIM_KINDS * BYTES_PER_LIM,
    localparam int SLOT      = LIM_KINDS * BYTES_PER_LIM,
    localparam int FW        = 2 * NCH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCH-1:0]              upd,
    input  logic [NCH-1:0][SW-1:0]      smp_in,
    input  logic [LIM_BYTES-1:0][7:0]   lim_i,
    output logic [FW-1:0]               alm_o,
    output logic [FW-1:0]               wrn_o
);
    typedef struct packed {
        logic [FW-1:0] alm;
        logic [FW-1:0] wrn;
    } flag_st_t;

    flag_st_t s_d, s_q;

    // per channel: [0] above high alarm, [1] below low alarm,
    //              [2] above high warning, [3] below low warning
    logic [NCH-1:0][LIM_KINDS-1:0] hit;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [LIM_KINDS-1:0][SW-1:0] lim;
        for (genvar k = 0; k < LIM_KINDS; k++) begin : g_lim
            assign lim[k] = {lim_i[c*SLOT + 2*k], lim_i[c*SLOT + 2*k + 1]};
        end
        if (SIGNED_MASK[c]) begin : g_signed
            assign hit[c][0] = $signed(smp_in[c]) > $signed(lim[LIM_HI_ALM]);
            assign hit[c][1] = $signed(smp_in[c]) < $signed(lim[LIM_LO_ALM]);
            assign hit[c][2] = $signed(smp_in[c]) > $signed(lim[LIM_HI_WRN]);
            assign hit[c][3] = $signed(smp_in[c]) < $signed(lim[LIM_LO_WRN]);
        end else begin : g_unsigned
            assign hit[c][0] = smp_in[c] > lim[LIM_HI_ALM];
            assign hit[c][1] = smp_in[c] < lim[LIM_LO_ALM];
            assign hit[c][2] = smp_in[c] > lim[LIM_HI_WRN];
            assign hit[c][3] = smp_in[c] < lim[LIM_LO_WRN];
        end
    end

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NCH; c++) begin
            if (upd[c]) begin
                s_d.alm[2*(NCH-1-c)+1] = hit[c][0];
                s_d.alm[2*(NCH-1-c)]   = hit[c][1];
                s_d.wrn[2*(NCH-1-c)+1] = hit[c][2];
                s_d.wrn[2*(NCH-1-c)]   = hit[c][3];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alm_o = s_q.alm;
    assign wrn_o = s_q.wrn;

    // R9
    flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == '0) |=> ($stable(alm_o) && $stable(wrn_o)));

    for (genvar c = 0; c < NCH; c++) begin : g_own
        // R9
        flags_own_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !upd[c] |=> ($stable(alm_o[2*(NCH-1-c) +: 2]) && $stable(wrn_o[2*(NCH-1-c) +: 2])));
    end
endmodule

// File: rtl/dmon_alarm_flags.sv
module dmon_alarm_flags
    import dmon_pkg::*;
#(
    parameter int             NCH         = 5,
    parameter int             SW          = 16,
    parameter int             AW          = 8,
    parameter logic [NCH-1:0] SIGNED_MASK = 5'b00001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [AW-1:0]     reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NCH*SW-1:0] smp_data,
    input  logic [NCH-1:0]    smp_upd
);
    localparam int LIM_BYTES = NCH * LIM_KINDS * BYTES_PER_LIM;
    localparam int LAW       = $clog2(LIM_BYTES);
    localparam int CW        = $clog2(NCH);
    localparam int FW        = 2 * NCH;
    localparam int PAD       = 16 - FW;

    localparam logic [AW-1:0] LIM_TOP = AW'(LIM_BYTES);
    localparam logic [AW-1:0] RT_BASE = AW'(RT_BASE_ADDR);
    localparam logic [AW-1:0] RT_TOP  = AW'(RT_BASE_ADDR + 2 * NCH);
    localparam logic [AW-1:0] A_ALM_H = AW'(ALM_HI_ADDR);
    localparam logic [AW-1:0] A_ALM_L = AW'(ALM_LO_ADDR);
    localparam logic [AW-1:0] A_WRN_H = AW'(WRN_HI_ADDR);
    localparam logic [AW-1:0] A_WRN_L = AW'(WRN_LO_ADDR);

    logic [LIM_BYTES-1:0][7:0] lim;
    logic [NCH-1:0][SW-1:0]    smp_in;
    logic [NCH-1:0][SW-1:0]    smp_q;
    logic [FW-1:0]             alm;
    logic [FW-1:0]             wrn;
    logic [15:0]               alm_word;
    logic [15:0]               wrn_word;
    logic [AW-1:0]             rt_idx;
    logic [CW-1:0]             rt_ch;

    assign smp_in = smp_data;

    dmon_limit_bank #(.NCH(NCH), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .lim_o   (lim)
    );

    dmon_sample_regs #(.NCH(NCH), .SW(SW)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (smp_upd),
        .smp_in (smp_in),
        .smp_o  (smp_q)
    );

    dmon_flag_cmp #(.NCH(NCH), .SW(SW), .SIGNED_MASK(SIGNED_MASK)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (smp_upd),
        .smp_in (smp_in),
        .lim_i  (lim),
        .alm_o  (alm),
        .wrn_o  (wrn)
    );

    assign alm_word = {alm, {PAD{1'b0}}};
    assign wrn_word = {wrn, {PAD{1'b0}}};
    assign rt_idx   = reg_addr - RT_BASE;
    assign rt_ch    = rt_idx[CW:1];

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr < LIM_TOP) begin
            reg_rdata = lim[reg_addr[LAW-1:0]];
        end else if (reg_addr >= RT_BASE && reg_addr < RT_TOP) begin
            reg_rdata = rt_idx[0] ? smp_q[rt_ch][7:0] : smp_q[rt_ch][SW-1:8];
        end else if (reg_addr == A_ALM_H) begin
            reg_rdata = alm_word[15:8];
        end else if (reg_addr == A_ALM_L) begin
            reg_rdata = alm_word[7:0];
        end else if (reg_addr == A_WRN_H) begin
            reg_rdata = wrn_word[15:8];
        end else if (reg_addr == A_WRN_L) begin
            reg_rdata = wrn_word[7:0];
        end
    end

    // R7
    reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_ALM_L || reg_addr == A_WRN_L) |-> reg_rdata[5:0] == 6'd0);

    // R10
    gap_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= LIM_TOP && reg_addr < RT_BASE) |-> reg_rdata == 8'h00);
endmodule

// File: tb/dmon_alarm_flags_tb.sv
`timescale 1ns/1ps
module dmon_alarm_flags_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [79:0] smp_data = '0;
    logic [4:0]  smp_upd = '0;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_lim [5][4];
    logic [15:0] m_smp [5];
    bit          m_fh  [2][5];
    bit          m_fl  [2][5];

    always #4 clk = ~clk;

    dmon_alarm_flags u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .smp_data  (smp_data),
        .smp_upd   (smp_upd)
    );

    function automatic bit f_gt(int c, logic [15:0] a, logic [15:0] b);
        if (c == 0) return $signed(a) > $signed(b);
        return a > b;
    endfunction

    function automatic bit f_lt(int c, logic [15:0] a, logic [15:0] b);
        if (c == 0) return $signed(a) < $signed(b);
        return a < b;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        int ai = int'(a);
        if (ai < 40) begin
            logic [15:0] v = m_lim[ai / 8][(ai % 8) / 2];
            return ai[0] ? v[7:0] : v[15:8];
        end
        if (ai >= 96 && ai < 106) begin
            logic [15:0] v = m_smp[(ai - 96) / 2];
            return ai[0] ? v[7:0] : v[15:8];
        end
        if (ai == 112 || ai == 116) begin
            int k = (ai == 112) ? 0 : 1;
            return {m_fh[k][0], m_fl[k][0], m_fh[k][1], m_fl[k][1],
                    m_fh[k][2], m_fl[k][2], m_fh[k][3], m_fl[k][3]};
        end
        if (ai == 113 || ai == 117) begin
            int k = (ai == 113) ? 0 : 1;
            return {m_fh[k][4], m_fl[k][4], 6'b000000};
        end
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [7:0] a, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, act, exp);
        end
    endtask

    task automatic rd_chk(string tag, logic [7:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, a, reg_rdata, exp_rd(a));
    endtask

    task automatic cycle(bit we, logic [7:0] a, logic [7:0] d, logic [4:0] up, logic [79:0] sd);
        @(negedge clk);
        reg_wr_en = we; reg_addr = a; reg_wdata = d; smp_upd = up; smp_data = sd;
        @(posedge clk);
        for (int c = 0; c < 5; c++) begin
            if (up[c]) begin
                logic [15:0] s = sd[c*16 +: 16];
                m_smp[c]   = s;
                m_fh[0][c] = f_gt(c, s, m_lim[c][0]);
                m_fl[0][c] = f_lt(c, s, m_lim[c][1]);
                m_fh[1][c] = f_gt(c, s, m_lim[c][2]);
                m_fl[1][c] = f_lt(c, s, m_lim[c][3]);
            end
        end
        if (we && a < 8'd40) begin
            if (a[0]) m_lim[a / 8][(a % 8) / 2][7:0]  = d;
            else      m_lim[a / 8][(a % 8) / 2][15:8] = d;
        end
        #1;
        reg_wr_en = 1'b0; smp_upd = '0;
    endtask

    task automatic set_lim(int c, int k, logic [15:0] v);
        cycle(1'b1, 8'(c*8 + k*2),     v[15:8], 5'd0, 80'd0);
        cycle(1'b1, 8'(c*8 + k*2 + 1), v[7:0],  5'd0, 80'd0);
    endtask

    task automatic strobe(int c, logic [15:0] v);
        logic [79:0] sd = '0;
        sd[c*16 +: 16] = v;
        cycle(1'b0, 8'd0, 8'd0, 5'(1 << c), sd);
    endtask

    task automatic flags_chk(string tag);
        rd_chk(tag, 8'd112);
        rd_chk(tag, 8'd113);
        rd_chk(tag, 8'd116);
        rd_chk(tag, 8'd117);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int c = 0; c < 5; c++) begin
            m_smp[c] = '0;
            for (int k = 0; k < 4; k++) m_lim[c][k] = '0;
            m_fh[0][c] = 0; m_fl[0][c] = 0; m_fh[1][c] = 0; m_fl[1][c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 reset limit", 8'd0);
        rd_chk("R1 reset limit", 8'd39);
        rd_chk("R1 reset reading", 8'd96);
        rd_chk("R1 reset reading", 8'd105);
        flags_chk("R1 reset flags");

        // R2: limit placement and readback
        set_lim(3, 2, 16'hA55A);
        rd_chk("R2 limit msb", 8'd28);
        rd_chk("R2 limit lsb", 8'd29);

        // R6 and R5: signed temperature below zero
        set_lim(0, 1, 16'h0000);
        strobe(0, 16'hFFFF);
        flags_chk("R6 R5 temp -1 vs low 0");
        rd_chk("R3 reading msb", 8'd96);
        rd_chk("R3 reading lsb", 8'd97);

        // R6: unsigned supply above 0x7FFF
        set_lim(1, 0, 16'h7FFF);
        strobe(1, 16'hFFFF);
        flags_chk("R6 supply unsigned high");

        // R4: equality does not flag, one above does
        set_lim(2, 0, 16'h1234);
        strobe(2, 16'h1234);
        flags_chk("R4 bias equal high");
        strobe(2, 16'h1235);
        flags_chk("R4 bias above high");

        // R5: equality on low limit
        set_lim(2, 1, 16'h1000);
        strobe(2, 16'h1000);
        flags_chk("R5 bias equal low");
        strobe(2, 16'h0FFF);
        flags_chk("R5 bias below low");

        // R8 and R7: receive power warnings land in byte 117
        set_lim(4, 2, 16'h0100);
        set_lim(4, 3, 16'h0080);
        strobe(4, 16'h0200);
        flags_chk("R8 R7 rx high warning");
        strobe(4, 16'h0010);
        flags_chk("R8 R7 rx low warning");

        // R9: limit write and strobe in the same cycle use the old limit
        set_lim(3, 0, 16'h5000);
        begin
            logic [79:0] sd = '0;
            sd[48 +: 16] = 16'h40FF;
            cycle(1'b1, 8'd24, 8'h40, 5'b01000, sd);
        end
        flags_chk("R9 collision uses old limit");
        rd_chk("R9 collision write landed", 8'd24);
        strobe(3, 16'h40FF);
        flags_chk("R9 next strobe uses new limit");
        set_lim(3, 0, 16'hFFFF);
        flags_chk("R9 limit change without strobe");

        // R10: read-only and unmapped writes ignored
        cycle(1'b1, 8'd112, 8'hFF, 5'd0, 80'd0);
        rd_chk("R10 flag byte write ignored", 8'd112);
        cycle(1'b1, 8'd96, 8'h5A, 5'd0, 80'd0);
        rd_chk("R10 reading write ignored", 8'd96);
        cycle(1'b1, 8'd50, 8'h77, 5'd0, 80'd0);
        rd_chk("R10 unmapped read zero", 8'd50);
        rd_chk("R10 unmapped read zero", 8'd114);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 3);
            logic [79:0] sd = '0;
            logic [4:0]  up = 5'($urandom_range(0, 31));
            logic [7:0]  a  = 8'($urandom_range(0, 39));
            logic [7:0]  d  = 8'($urandom);
            for (int c = 0; c < 5; c++) begin
                logic [15:0] base = m_lim[c][$urandom_range(0, 3)];
                if ($urandom_range(0, 3) != 0) sd[c*16 +: 16] = base + 16'($urandom_range(0, 4)) - 16'd2;
                else                           sd[c*16 +: 16] = 16'($urandom);
            end
            case (op)
                0: cycle(1'b1, a, d, 5'd0, 80'd0);
                1: cycle(1'b1, 8'($urandom_range(0, 127)), d, 5'd0, 80'd0);
                2: cycle(1'b0, 8'd0, 8'd0, up, sd);
                default: cycle(1'b1, a, d, up, sd);
            endcase
            flags_chk("R4 R5 R8 R9 random flags");
            rd_chk("R2 R3 R10 random readback", 8'($urandom_range(0, 127)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule